// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus, in front of a 256-byte by 8-bit register-file memory. A fast system clock oversamples the bus clock and data lines through two-flop synchronizers. Edge logic then finds START and STOP conditions and shifts bytes in and out. Three strap inputs give the device address. Up to eight of these slaves can therefore share one bus, each under the device-type code 1011.

A write has three parts: the device address, one word-address byte, and then data bytes. The data bytes go into a 16-entry page staging buffer and are written to memory only when STOP arrives. The write-protect input can veto that commit. A commit starts a fixed busy interval, and the slave ignores its own address until the interval ends. A read sends bytes from an internal address counter. It continues for as long as the master acknowledges each byte and stops at the first missing acknowledge. The data line is never driven high: the block only gives an open-drain pull-low enable.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset the pull-low enable is 0 and every memory byte reads as 0x00.
- R2: START means data falls while clock is high, and STOP means data rises while clock is high. Before the first START the slave acknowledges nothing, and a START releases the data line.
- R3: The slave acknowledges an address byte only when bits 7..4 are 1011 and bits 3..1 equal the strap inputs (bit 3 = strap[2]). After a mismatch it drives nothing until the next START or STOP.
- R4: The acknowledge pulls data low for the whole ninth clock. In write mode every received byte is acknowledged. The enable changes only while the bus clock is low.
- R5: In a write, the second byte sets the word address and later bytes fill the page buffer. The low four address bits wrap within the 16-byte page and the upper four stay fixed. Memory changes only at STOP.
- R6: If the write-protect input is high at STOP, nothing is committed, even though every byte was acknowledged.
- R7: A commit starts a busy interval of BUSY_CYCLES system clocks. During it the device address is not acknowledged, and after it the address is acknowledged again.
- R8: Address bit 0 selects direction: 1 = read, 0 = write. A write of only the word address, followed by a repeated START and a read, returns data from that address.
- R9: A read moves the counter up by one per byte and wraps it from 255 to 0. It sends another byte after each master acknowledge.
- R10: After a byte the master does not acknowledge, the slave keeps the data line released until START or STOP.
- R11: A read sent without a word address starts at the current value of the address counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 3 | Device address straps compared with address bits 3..1 |
| wp_i | input | 1 | Write protect; high blocks the commit at STOP |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls the data line low |

## Verification
The busy interval is the hardest condition to reach. It exists only between a committing STOP and BUSY_CYCLES clocks later, and software cannot see it. The bench addresses the slave again right after a page write, while the interval is still running, and expects a missing acknowledge. It then waits out the interval and expects the acknowledge to return. The end of a read is also hard to observe. The bench clocks an extra byte after its own missing acknowledge and checks that the line reads all ones, although the next memory byte is known to be non-zero.

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
  parameter logic [3:0] DEV_TYPE    = 4'b1011,
  parameter int         MEM_AW      = 8,
  parameter int         PAGE_AW     = 4,
  parameter int         BUSY_CYCLES = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam int MEM_DEPTH = 1 << MEM_AW;
  localparam int PAGE_LEN  = 1 << PAGE_AW;
  localparam int BUSY_W    = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WADDR, S_WDATA, S_RDATA, S_WAIT} state_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic       scl_s, sda_s;
  logic       start_c, stop_c, scl_rise, scl_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  assign scl_s    = scl_sy[1];
  assign sda_s    = sda_sy[1];
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;

  state_t              state;
  logic [3:0]          cnt;
  logic [7:0]          shreg, txreg;
  logic [MEM_AW-1:0]   addr;
  logic                mack;
  logic [7:0]          pbuf [PAGE_LEN];
  logic [PAGE_LEN-1:0] pvalid;
  logic [7:0]          mem  [MEM_DEPTH];
  logic [BUSY_W-1:0]   busy_cnt;
  logic                busy, dev_match, commit, parked;
  logic [7:0]          rd_byte;

  assign busy      = busy_cnt != '0;
  assign dev_match = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == strap_i);
  assign commit    = stop_c && (pvalid != '0) && !wp_i;
  assign parked    = (state == S_IDLE) || (state == S_WAIT);
  assign rd_byte   = mem[addr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < PAGE_LEN; i++)
        if (commit && pvalid[i]) mem[{addr[MEM_AW-1:PAGE_AW], PAGE_AW'(i)}] <= pbuf[i];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      busy_cnt <= '0;
    else if (commit) busy_cnt <= BUSY_W'(BUSY_CYCLES);
    else if (busy)   busy_cnt <= busy_cnt - BUSY_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      txreg    <= '0;
      addr     <= '0;
      mack     <= 1'b0;
      pvalid   <= '0;
      sda_oe_o <= 1'b0;
      for (int i = 0; i < PAGE_LEN; i++) pbuf[i] <= '0;
    end else if (start_c) begin
      state    <= S_DEV;
      cnt      <= '0;
      pvalid   <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_c) begin
      state    <= S_IDLE;
      cnt      <= '0;
      pvalid   <= '0;
      sda_oe_o <= 1'b0;
    end else if (!parked) begin
      if (scl_rise) begin
        if (cnt < 4'd8) shreg <= {shreg[6:0], sda_s};
        if (cnt == 4'd8) mack <= ~sda_s;
        if (cnt != 4'd9) cnt <= cnt + 4'd1;
      end else if (scl_fall) begin
        if (cnt == 4'd8) begin
          unique case (state)
            S_DEV: begin
              if (dev_match && !busy) begin
                sda_oe_o <= 1'b1;
                state    <= shreg[0] ? S_RDATA : S_WADDR;
              end else begin
                state    <= S_WAIT;
              end
            end
            S_WADDR: begin
              addr     <= shreg[MEM_AW-1:0];
              sda_oe_o <= 1'b1;
              state    <= S_WDATA;
            end
            S_WDATA: begin
              pbuf[addr[PAGE_AW-1:0]]   <= shreg;
              pvalid[addr[PAGE_AW-1:0]] <= 1'b1;
              addr     <= {addr[MEM_AW-1:PAGE_AW], addr[PAGE_AW-1:0] + PAGE_AW'(1)};
              sda_oe_o <= 1'b1;
            end
            default: sda_oe_o <= 1'b0;
          endcase
        end else if (cnt == 4'd9) begin
          cnt      <= '0;
          sda_oe_o <= 1'b0;
          if (state == S_RDATA) begin
            if (mack) begin
              txreg    <= rd_byte;
              addr     <= addr + MEM_AW'(1);
              sda_oe_o <= ~rd_byte[7];
            end else begin
              state    <= S_WAIT;
            end
          end
        end else if (state == S_RDATA && cnt != 4'd0) begin
          sda_oe_o <= ~txreg[6];
          txreg    <= {txreg[6:0], 1'b0};
        end
      end
    end
endmodule

module twi_eeprom_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe_o,
  input logic start_c,
  input logic stop_c,
  input logic wp_i,
  input logic commit,
  input logic busy,
  input logic parked
);
  p_parked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    parked |-> !sda_oe_o);
  p_start_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (!sda_oe_o && !parked));
  p_commit_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);
  p_wp_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_i && stop_c && !busy) |=> !busy);
  p_oe_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);
endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .start_c(start_c), .stop_c(stop_c), .wp_i(wp_i), .commit(commit),
  .busy(busy), .parked(parked)
);

// File: tb/twi_eeprom_slave_tb.sv
module twi_eeprom_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;
  localparam int SETTLE     = 500;

  logic       clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic       oe;
  logic       line;
  assign line = sda_m & ~oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_eeprom_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line),
    .strap_i(strap), .wp_i(wp), .sda_oe_o(oe)
  );

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$], act_q[$];
  string      tag_q[$];
  logic [7:0] devw, devr;
  assign devw = {4'b1011, strap, 1'b0};
  assign devr = {4'b1011, strap, 1'b1};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(Q); scl = 1'b1; wclk(Q); sda_m = 1'b0; wclk(Q); scl = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(Q); scl = 1'b1; wclk(Q); sda_m = 1'b1; wclk(Q);
  endtask

  task automatic clock_bit(input bit b, output bit seen);
    sda_m = b; wclk(Q); scl = 1'b1; wclk(Q); seen = line; wclk(Q); scl = 1'b0; wclk(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic wr_ack(input logic [7:0] b, input string tag);
    bit a;
    wr_byte(b, a);
    chk(a == 1'b1, tag, a, 1);
  endtask

  task automatic rd_byte(input bit give_ack);
    logic [7:0] v;
    bit s;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, s);
      v = {v[6:0], s};
    end
    clock_bit(!give_ack, s);
    act_q.push_back(v);
  endtask

  task automatic expect_rd(input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic read_at(input logic [7:0] a);
    bus_start();
    wr_ack(devw, "R4 devw");
    wr_ack(a, "R8 word address");
    bus_start();
    wr_ack(devr, "R8 devr");
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (act_q.size() > 0) begin
        logic [7:0] a, e;
        string t;
        a = act_q.pop_front();
        if (exp_q.size() == 0) begin
          chk(1'b0, "scoreboard-empty", a, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(a == e, t, a, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit a, s;
    logic [7:0] v;
    wclk(5);
    chk(oe == 1'b0, "R1 oe in reset", oe, 0);
    rst_n = 1'b1;
    wclk(5);
    chk(oe == 1'b0, "R1 oe after reset", oe, 0);

    // R2: no START yet, address must not be acknowledged
    wr_byte(devw, a);
    chk(a == 1'b0, "R2 no ack before START", a, 0);
    bus_stop();

    // R3: strap mismatch, then a following byte stays ignored
    bus_start();
    wr_byte({4'b1011, 3'b000, 1'b0}, a);
    chk(a == 1'b0, "R3 strap mismatch", a, 0);
    wr_byte(8'h00, a);
    chk(a == 1'b0, "R3 ignored after mismatch", a, 0);
    bus_stop();
    bus_start();
    wr_byte({4'b1010, strap, 1'b0}, a);
    chk(a == 1'b0, "R3 prefix mismatch", a, 0);
    bus_stop();

    // R5: page write wrapping inside the page 0x10..0x1F
    bus_start();
    wr_ack(devw, "R4 devw");
    wr_ack(8'h1E, "R4 word address");
    wr_ack(8'h11, "R5 data0");
    wr_ack(8'h22, "R5 data1");
    wr_ack(8'h33, "R5 data2");
    wr_ack(8'h44, "R5 data3");
    bus_stop();

    // R7: still busy right after commit
    bus_start();
    wr_byte(devw, a);
    chk(a == 1'b0, "R7 nack while busy", a, 0);
    bus_stop();
    wclk(SETTLE);

    read_at(8'h10);
    expect_rd(8'h33, "R5 wrapped byte at 0x10");
    expect_rd(8'h44, "R9 sequential 0x11");
    expect_rd(8'h00, "R9 sequential 0x12");
    rd_byte(1'b1); rd_byte(1'b1); rd_byte(1'b0);
    bus_stop();

    read_at(8'h1E);
    expect_rd(8'h11, "R5 byte at 0x1E");
    expect_rd(8'h22, "R5 byte at 0x1F");
    rd_byte(1'b1); rd_byte(1'b0);
    bus_stop();

    read_at(8'h80);
    expect_rd(8'h00, "R1 memory cleared");
    rd_byte(1'b0);
    bus_stop();

    // R6: write protect
    wp = 1'b1;
    bus_start();
    wr_ack(devw, "R6 devw under protect");
    wr_ack(8'h40, "R6 word address under protect");
    wr_ack(8'h5A, "R6 data acked under protect");
    bus_stop();
    wp = 1'b0;
    wclk(SETTLE);
    read_at(8'h40);
    expect_rd(8'h00, "R6 protected byte unchanged");
    rd_byte(1'b0);
    bus_stop();

    // R9: wrap 255 -> 0
    bus_start();
    wr_ack(devw, "R4 devw");
    wr_ack(8'hFF, "R4 word address");
    wr_ack(8'h77, "R4 data");
    bus_stop();
    wclk(SETTLE);
    read_at(8'hFF);
    expect_rd(8'h77, "R9 byte at 0xFF");
    expect_rd(8'h00, "R9 wrapped to 0x00");
    rd_byte(1'b1); rd_byte(1'b0);
    bus_stop();

    // R10 / R11: NACK ends transfer, then current-address read
    bus_start();
    wr_ack(devw, "R4 devw");
    wr_ack(8'h05, "R4 word address");
    wr_ack(8'hA5, "R4 data");
    wr_ack(8'hB6, "R4 data");
    bus_stop();
    wclk(SETTLE);
    read_at(8'h05);
    expect_rd(8'hA5, "R8 random read 0x05");
    rd_byte(1'b0);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, s);
      v = {v[6:0], s};
    end
    clock_bit(1'b1, s);
    chk(v == 8'hFF, "R10 released after master nack", v, 8'hFF);
    bus_stop();
    bus_start();
    wr_ack(devr, "R11 devr current address");
    expect_rd(8'hB6, "R11 current address 0x06");
    rd_byte(1'b0);
    bus_stop();

    wclk(20);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule